// File: doc/BRIEF.md
# UART Receive FIFO with DMA Request Lines

This block sits between a UART receiver and an external DMA controller. The receiver hands it characters through a write strobe. Each character is a 12-bit word: eight data bits and four line-status bits. The characters are kept in a first-in first-out store. The block raises two request lines towards the DMA controller. The single request means that at least one character is waiting. The burst request means that the store holds more characters than a programmable watermark.

The DMA controller takes characters through a show-ahead read port. It pulses a clear input to drop both requests, and for a burst it does so on the final beat. After a clear, the requests stay quiet for one more cycle and are then rebuilt from the current fill level. Software may change the watermark selector at any time. While receive DMA is off, both requests are held low and a per-character interrupt line is driven instead. While receive DMA is on, that interrupt is masked.

Top module: `uart_rx_dma_req`

## Requirements
- R1: The store holds 16 words of 12 bits. Reads return words in write order, unchanged. Bits [7:0] carry data and bits [11:8] carry status (11 overrun, 10 break, 9 parity, 8 framing). `dma_char_o` shows the oldest word, and `dma_rd_i` removes it on a clock edge.
- R2: `req_single_o` is high when DMA is enabled, no clear window is active and at least one word is stored.
- R3: `req_burst_o` is high when DMA is enabled, no clear window is active and the stored count is strictly greater than the watermark.
- R4: The `mark_sel_i` codes 0, 1, 2, 3 and 4 give watermarks of 2, 4, 8, 12 and 14 words. Codes 5, 6 and 7 give 8. A change of code takes effect in the same cycle.
- R5: Both requests are low in every cycle in which `dma_clr_i` is high, and in the cycle that follows. After that they follow R2 and R3 again.
- R6: When `dma_en_i` is 0, both requests are low whatever the fill level.
- R7: `rx_char_irq_o` is high exactly when `dma_en_i` is 0 and at least one word is stored.
- R8: A write to a full store is dropped, the stored contents stay unchanged, and `overrun_o` goes high and stays high until reset.
- R9: A read from an empty store has no effect. The store stays empty and later writes are read back normally.
- R10: After reset the store is empty, both requests and the interrupt are low, and `overrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_wr_i | input | 1 | Character write strobe from the receiver |
| rx_char_i | input | 12 | Character word: status in [11:8], data in [7:0] |
| dma_rd_i | input | 1 | Pop strobe from the DMA controller |
| dma_char_o | output | 12 | Oldest stored character (show-ahead) |
| dma_en_i | input | 1 | Receive DMA enable |
| mark_sel_i | input | 3 | Watermark selector |
| dma_clr_i | input | 1 | Request clear from the DMA controller |
| req_single_o | output | 1 | Single-transfer request |
| req_burst_o | output | 1 | Burst request |
| rx_char_irq_o | output | 1 | Per-character receive interrupt, masked while DMA is on |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `dma_clr_i` and `dma_en_i` are clean single-bit levels, sampled on the clock, and that reset is held for at least one edge. They also assume that the watermark selector may change on any cycle, so the burst check compares against the decoded level of that same cycle. The stimulus drives every input one nanosecond after a rising edge and holds it for a whole cycle, so each strobe lasts exactly one edge. The bench pops characters only through the read port, and it issues clears only while requests are being tested.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   localparam int unsigned CHAR_W = 12;
   localparam int unsigned SEL_W  = 3;

   // watermark in entries for a selector code; reserved codes map to half
   function automatic int unsigned mark_entries(input logic [SEL_W-1:0] sel,
                                                input int unsigned depth);
      case (sel)
         3'd0:    return depth / 8;
         3'd1:    return depth / 4;
         3'd2:    return depth / 2;
         3'd3:    return (3 * depth) / 4;
         3'd4:    return (7 * depth) / 8;
         default: return depth / 2;
      endcase
   endfunction
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
   parameter int unsigned WIDTH = 12,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic [CW-1:0]    count_o,
   output logic             ovr_o
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [CW-1:0]    count_q;
   logic             ovr_q;
   logic             full, empty, push, pop;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 8) begin : g_bad_depth
         $error("rxdma_fifo: DEPTH must be a power of two of at least 8");
      end
   endgenerate

   assign full  = (count_q == FULL);
   assign empty = (count_q == '0);
   assign push  = wr_i & ~full;
   assign pop   = rd_i & ~empty;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push && wptr_q == AW'(i)) mem[i] <= wdata_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
         ovr_q   <= 1'b0;
      end else begin
         if (push) wptr_q <= wptr_q + 1'b1;
         if (pop)  rptr_q <= rptr_q + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
         if (wr_i && full) ovr_q <= 1'b1;
      end
   end

   assign rdata_o = mem[rptr_q];
   assign count_o = count_q;
   assign ovr_o   = ovr_q;

   // R1: the fill level never passes the depth
   a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL);
   // R8: a write into a full store leaves it full and raises overrun
   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && full && !rd_i) |=> (count_q == FULL) && ovr_q);
   // R8: overrun is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> ovr_q);
   // R9: a read of an empty store changes nothing
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && empty && !wr_i) |=> (count_q == '0) && $stable(rptr_q));
endmodule

// File: rtl/rxdma_mark_dec.sv
module rxdma_mark_dec
   import rxdma_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [CW-1:0]    mark_o
);
   generate
      if (DEPTH % 8 != 0) begin : g_bad_depth
         $error("rxdma_mark_dec: DEPTH must be a multiple of 8");
      end
   endgenerate

   always_comb begin
      mark_o = CW'(mark_entries(sel_i, DEPTH));
   end

   // R4: the decoded level stays strictly below the depth
   a_r4_range: assert property (@(sel_i) 1'b1 |-> (mark_o < CW'(DEPTH)))
      else $error("watermark out of range");
endmodule

// File: rtl/rxdma_req_ctrl.sv
module rxdma_req_ctrl #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          clr_i,
   input  logic [CW-1:0] count_i,
   input  logic [CW-1:0] mark_i,
   output logic          single_o,
   output logic          burst_o,
   output logic          irq_o
);
   logic hold_q;
   logic quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= clr_i;
   end

   assign quiet    = clr_i | hold_q | ~en_i;
   assign single_o = ~quiet & (count_i != '0);
   assign burst_o  = ~quiet & (count_i > mark_i);
   assign irq_o    = ~en_i & (count_i != '0);

   // R2: a single request implies stored data
   a_r2_single_data: assert property (@(posedge clk) disable iff (!rst_n)
      single_o |-> (count_i != '0));
   // R3: a burst request implies a level above the mark
   a_r3_burst_level: assert property (@(posedge clk) disable iff (!rst_n)
      burst_o |-> (count_i > mark_i));
   // R3: a burst request implies a single request
   a_r3_burst_single: assert property (@(posedge clk) disable iff (!rst_n)
      burst_o |-> single_o);
   // R5: the cycle after a clear has no request
   a_r5_clear_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> !single_o && !burst_o);
   // R6: DMA off silences both requests
   a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !single_o && !burst_o);
   // R7: the interrupt only runs while DMA is off
   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !en_i);
endmodule

// File: rtl/uart_rx_dma_req.sv
module uart_rx_dma_req
   import rxdma_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_wr_i,
   input  logic [CHAR_W-1:0] rx_char_i,
   input  logic              dma_rd_i,
   output logic [CHAR_W-1:0] dma_char_o,
   input  logic              dma_en_i,
   input  logic [SEL_W-1:0]  mark_sel_i,
   input  logic              dma_clr_i,
   output logic              req_single_o,
   output logic              req_burst_o,
   output logic              rx_char_irq_o,
   output logic              overrun_o
);
   logic [CW-1:0] level;
   logic [CW-1:0] mark;

   rxdma_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (rx_wr_i),
      .wdata_i (rx_char_i),
      .rd_i    (dma_rd_i),
      .rdata_o (dma_char_o),
      .count_o (level),
      .ovr_o   (overrun_o)
   );

   rxdma_mark_dec #(.DEPTH(DEPTH)) u_mark (
      .sel_i  (mark_sel_i),
      .mark_o (mark)
   );

   rxdma_req_ctrl #(.DEPTH(DEPTH)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (dma_en_i),
      .clr_i    (dma_clr_i),
      .count_i  (level),
      .mark_i   (mark),
      .single_o (req_single_o),
      .burst_o  (req_burst_o),
      .irq_o    (rx_char_irq_o)
   );

   // R10: requests stay low while the store is empty
   a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> !req_single_o && !req_burst_o && !rx_char_irq_o);
endmodule

// File: tb/uart_rx_dma_req_tb.sv
module uart_rx_dma_req_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_wr_i = 1'b0;
   logic [11:0] rx_char_i = '0;
   logic        dma_rd_i = 1'b0;
   logic [11:0] dma_char_o;
   logic        dma_en_i = 1'b1;
   logic [2:0]  mark_sel_i = 3'd2;
   logic        dma_clr_i = 1'b0;
   logic        req_single_o, req_burst_o, rx_char_irq_o, overrun_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   logic [11:0] model[$];

   always #4 clk = ~clk;

   uart_rx_dma_req u_dut (
      .clk(clk), .rst_n(rst_n), .rx_wr_i(rx_wr_i), .rx_char_i(rx_char_i),
      .dma_rd_i(dma_rd_i), .dma_char_o(dma_char_o), .dma_en_i(dma_en_i),
      .mark_sel_i(mark_sel_i), .dma_clr_i(dma_clr_i),
      .req_single_o(req_single_o), .req_burst_o(req_burst_o),
      .rx_char_irq_o(rx_char_irq_o), .overrun_o(overrun_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [11:0] w);
      rx_wr_i = 1'b1; rx_char_i = w;
      step();
      rx_wr_i = 1'b0;
      if (model.size() < 16) model.push_back(w);
   endtask

   task automatic pop();
      dma_rd_i = 1'b1;
      step();
      dma_rd_i = 1'b0;
      if (model.size() > 0) void'(model.pop_front());
   endtask

   task automatic drain();
      while (model.size() > 0) pop();
   endtask

   function automatic int mark_of(input logic [2:0] s);
      case (s)
         3'd0: return 2;
         3'd1: return 4;
         3'd3: return 12;
         3'd4: return 14;
         default: return 8;
      endcase
   endfunction

   task automatic t_reset();
      chk("R10 single", req_single_o, 0);
      chk("R10 burst", req_burst_o, 0);
      chk("R10 irq", rx_char_irq_o, 0);
      chk("R10 overrun", overrun_o, 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 6; i++) push(12'((i * 12'h2a7) ^ (i << 8)));
      push(12'hF5A);
      while (model.size() > 0) begin
         chk("R1 order", dma_char_o, model[0]);
         pop();
      end
      chk("R1 empty after drain", req_single_o, 0);
   endtask

   task automatic t_single();
      mark_sel_i = 3'd2;
      push(12'h041);
      chk("R2 single one word", req_single_o, 1);
      chk("R3 no burst one word", req_burst_o, 0);
      drain();
      chk("R2 single empty", req_single_o, 0);
   endtask

   task automatic t_levels();
      for (int s = 0; s < 8; s++) begin
         mark_sel_i = 3'(s);
         for (int k = 0; k < mark_of(3'(s)); k++) push(12'(k + s * 16));
         chk($sformatf("R4 code %0d at mark no burst", s), req_burst_o, 0);
         chk($sformatf("R2 code %0d single", s), req_single_o, 1);
         push(12'h0AA);
         chk($sformatf("R3 R4 code %0d above mark burst", s), req_burst_o, 1);
         drain();
      end
      // run-time change of selector
      mark_sel_i = 3'd2;
      for (int k = 0; k < 9; k++) push(12'(k));
      chk("R4 nine over half", req_burst_o, 1);
      mark_sel_i = 3'd3;
      #1;
      chk("R4 switch to twelve", req_burst_o, 0);
      mark_sel_i = 3'd0;
      #1;
      chk("R4 switch to two", req_burst_o, 1);
      drain();
   endtask

   task automatic t_clear();
      mark_sel_i = 3'd0;
      for (int k = 0; k < 4; k++) push(12'(k + 1));
      chk("R3 before clear", req_burst_o, 1);
      dma_clr_i = 1'b1;
      #1;
      chk("R5 burst low during clear", req_burst_o, 0);
      chk("R5 single low during clear", req_single_o, 0);
      pop();
      dma_clr_i = 1'b0;
      #1;
      chk("R5 burst low after clear", req_burst_o, 0);
      chk("R5 single low after clear", req_single_o, 0);
      step();
      chk("R5 burst back", req_burst_o, 1);
      chk("R5 single back", req_single_o, 1);
      drain();
   endtask

   task automatic t_off_irq();
      dma_en_i = 1'b0;
      mark_sel_i = 3'd0;
      #1;
      chk("R7 irq empty", rx_char_irq_o, 0);
      for (int k = 0; k < 5; k++) push(12'(k + 7));
      chk("R6 single off", req_single_o, 0);
      chk("R6 burst off", req_burst_o, 0);
      chk("R7 irq off", rx_char_irq_o, 1);
      dma_en_i = 1'b1;
      #1;
      chk("R7 irq masked", rx_char_irq_o, 0);
      chk("R6 single on", req_single_o, 1);
      chk("R6 burst on", req_burst_o, 1);
      drain();
   endtask

   task automatic t_overrun();
      mark_sel_i = 3'd4;
      for (int k = 0; k < 16; k++) push(12'(12'h300 + k));
      chk("R8 no overrun at full", overrun_o, 0);
      push(12'hBAD);
      chk("R8 overrun set", overrun_o, 1);
      chk("R8 burst at full", req_burst_o, 1);
      while (model.size() > 0) begin
         chk("R8 contents", dma_char_o, model[0]);
         pop();
      end
      chk("R8 empty after", req_single_o, 0);
      chk("R8 sticky", overrun_o, 1);
   endtask

   task automatic t_empty_read();
      pop();
      pop();
      chk("R9 still empty", req_single_o, 0);
      push(12'h5C3);
      chk("R9 write after", dma_char_o, 12'h5C3);
      pop();
      push(12'h0E1);
      push(12'h0E2);
      chk("R9 order after", dma_char_o, 12'h0E1);
      drain();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_order();
      t_single();
      t_levels();
      t_clear();
      t_off_irq();
      t_empty_read();
      t_overrun();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule